// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a single-clock synchronous SRAM. Its read path is flow-through and it never needs idle cycles between transfers. A command is made of a new address or a burst step, a read/write select and a chip-select vote. It is captured on a rising clock edge. Read data appears in the cycle that follows that edge. Write data and its byte-lane enables are taken one edge later. This late-write scheme lets the bus change direction every cycle without a wait state. The shared data bus is split into an input port, an output port and an output-enable flag.

A two-bit burst counter lets the caller stream four words after one address load, in either linear or interleaved order. The order is fixed by the mode pin at the load. A clock-enable pin freezes the whole block, including a write that is waiting for its data. The storage array is parameterised and small, and each byte lane is held as its own storage slice.

Top module: `ssram_ft`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release with idle inputs, `doe` is 0 and `dout` is 0.
- R2: A read loaded at a clock edge (`adv`=0, `we_n`=1, selected) drives `doe`=1 and `dout` = the stored word at that address during the following cycle.
- R3: For a write loaded at edge k, data and byte enables are taken from `din`/`bw_n` at edge k+1. The value on `din` at edge k is not stored.
- R4: `bw_n[i]`=0 enables lane i (lane 0 = `din[8:0]`, lane 1 = `din[17:9]`). A lane whose enable is 1 keeps its old contents.
- R5: A load is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: `doe`=0 in the next cycle and no word is written.
- R6: With `adv`=1 the burst counter steps by one per enabled edge. The operation type of the last load (read, write or deselect) continues, and a write burst writes each step's data at the following edge.
- R7: With `mode`=0 at the load, burst step n accesses low address bits (base + n) mod 4.
- R8: With `mode`=1 at the load, burst step n accesses low address bits base XOR n.
- R9: During a burst the address bits above the lowest two keep their loaded value. The sequence wraps within the aligned group of four.
- R10: While `cke_n`=1 all inputs are ignored and all state holds. This includes a write waiting for its data and the word currently driven on `dout`.
- R11: Read, write, read commands may be issued on consecutive edges with no idle cycle. `doe`=0 during each write data cycle.
- R12: A read loaded at the same edge that completes a write to that address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high suspends the block |
| adv | input | 1 | 1 = step burst counter, 0 = load new address and command |
| we_n | input | 1 | 0 = write command, 1 = read command (on a load) |
| bw_n | input | NB (2) | Per-lane write enables, active low, sampled in the write data cycle |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| mode | input | 1 | Burst order on a load: 1 interleaved, 0 linear |
| addr | input | AW (6) | Word address |
| din | input | DW (18) | Write data |
| dout | output | DW (18) | Read data, 0 when not driven |
| doe | output | 1 | Output enable for the shared data bus |

## Verification
The hardest condition to reach is a write whose data edge is delayed by a suspend. Reaching it needs a write load, then one or more cycles with `cke_n` high while the data pins carry decoy values, then an enabled edge that both commits the real data and loads a read of the same word. The bench builds exactly that sequence. It also loads a read, suspends while another address is presented, and confirms that the driven word does not move. Burst ordering is checked by pre-filling an aligned group with distinct words and reading it back from a non-zero starting offset in both orders, which makes the wrap visible.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low address bits for burst step cnt from loaded base
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = base ^ cnt;
    else     r = base + cnt;
    return r;
  endfunction

endpackage

// File: rtl/ssram_burst_ctl.sv
module ssram_burst_ctl
  import ssram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          adv,
  input  logic          we_n,
  input  logic          sel,
  input  logic          mode,
  input  logic [AW-1:0] addr,
  output op_e           op,
  output logic [AW-1:0] eff_addr
);

  op_e           op_q, op_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          ilv_q, ilv_d;

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    ilv_d  = ilv_q;
    if (!cke_n) begin
      if (adv) begin
        cnt_d = cnt_q + 2'd1;
      end else begin
        base_d = addr;
        cnt_d  = 2'd0;
        ilv_d  = mode;
        if (!sel)      op_d = OP_IDLE;
        else if (!we_n) op_d = OP_WR;
        else            op_d = OP_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ilv_q  <= ilv_d;
    end
  end

  assign op       = op_q;
  assign eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, ilv_q)};

  // R10
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(op_q) && $stable(base_q) && $stable(cnt_q) && $stable(ilv_q)));

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(op_q) && $stable(base_q));

  // R9
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv) |=> (cnt_q == 2'd0) && (eff_addr == $past(addr)));

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int DW = 18,
  parameter int NB = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_be,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) begin
        lane_mem[wr_addr] <= wr_data[g*LW +: LW];
      end
    end

    assign rd_data[g*LW +: LW] = lane_mem[rd_addr];
  end

endmodule

// File: rtl/ssram_ft.sv
module ssram_ft
  import ssram_pkg::*;
#(
  parameter int DW = 18,
  parameter int NB = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          adv,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          doe
);

  op_e           op;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] rd_data;
  logic          sel;
  logic          wr_en;

  assign sel = !ce1_n && ce2 && !ce3_n;

  ssram_burst_ctl #(.AW(AW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .adv      (adv),
    .we_n     (we_n),
    .sel      (sel),
    .mode     (mode),
    .addr     (addr),
    .op       (op),
    .eff_addr (eff_addr)
  );

  // Late write: the current command stage is a write, so this edge carries its data
  assign wr_en = !cke_n && (op == OP_WR);

  ssram_array #(.DW(DW), .NB(NB), .AW(AW)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (eff_addr),
    .wr_data (din),
    .wr_be   (~bw_n),
    .rd_addr (eff_addr),
    .rd_data (rd_data)
  );

  assign doe  = (op == OP_RD);
  assign dout = doe ? rd_data : '0;

  // R5
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !sel) |=> !doe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && sel && we_n) |=> doe);

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && sel && !we_n) |=> !doe);

endmodule

// File: tb/ssram_ft_bench.sv
module ssram_ft_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CE_ON = 3'b010; // {ce1_n, ce2, ce3_n}

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke_n, adv, we_n, ce1_n, ce2, ce3_n, mode;
  logic [1:0]  bw_n;
  logic [5:0]  addr;
  logic [17:0] din;
  logic [17:0] dout;
  logic        doe;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssram_ft u_ssram_ft (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
    .addr(addr), .din(din), .dout(dout), .doe(doe)
  );

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one cycle of inputs, pass one rising edge, settle away from it
  task automatic drv(input logic ck, input logic av, input logic we,
                     input logic [2:0] ce, input logic md, input logic [5:0] a,
                     input logic [17:0] d, input logic [1:0] bw);
    cke_n = ck; adv = av; we_n = we;
    {ce1_n, ce2, ce3_n} = ce;
    mode = md; addr = a; din = d; bw_n = bw;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_load(input logic [5:0] a, input logic [17:0] d_prev, input logic [1:0] bw_prev);
    drv(1'b0, 1'b0, 1'b0, CE_ON, 1'b0, a, d_prev, bw_prev);
  endtask

  task automatic rd_load(input logic [5:0] a, input logic [17:0] d_prev, input logic [1:0] bw_prev);
    drv(1'b0, 1'b0, 1'b1, CE_ON, 1'b0, a, d_prev, bw_prev);
  endtask

  task automatic idle(input logic [17:0] d_prev, input logic [1:0] bw_prev);
    drv(1'b0, 1'b0, 1'b1, 3'b110, 1'b0, 6'd0, d_prev, bw_prev);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cke_n = 1'b0; adv = 1'b0; we_n = 1'b1; {ce1_n, ce2, ce3_n} = 3'b110;
    mode = 1'b0; addr = '0; din = '0; bw_n = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 doe in reset", {17'd0, doe}, 18'd0);
    chk("R1 dout in reset", dout, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(18'd0, 2'b11);
    chk("R1 doe after release", {17'd0, doe}, 18'd0);
  endtask

  task automatic t_rw_basic();
    wr_load(6'd3, 18'd0, 2'b11);
    wr_load(6'd5, 18'h01234, 2'b00);       // data for addr 3
    chk("R11 doe in write data cycle", {17'd0, doe}, 18'd0);
    rd_load(6'd3, 18'h2AAAA, 2'b00);       // data for addr 5
    chk("R2 doe on read", {17'd0, doe}, 18'd1);
    chk("R2 R11 read after write turn", dout, 18'h01234);
    rd_load(6'd5, 18'h3FFFF, 2'b00);
    chk("R11 back-to-back read", dout, 18'h2AAAA);
    // R3: value on din at the address edge must not be stored
    wr_load(6'd6, 18'h3FFFF, 2'b00);
    rd_load(6'd6, 18'h00055, 2'b00);
    chk("R3 R12 data taken one edge late", dout, 18'h00055);
    idle(18'd0, 2'b11);
    chk("R2 released on deselect", {17'd0, doe}, 18'd0);
  endtask

  task automatic t_bytes();
    logic [17:0] d1;
    d1 = 18'h15555;
    wr_load(6'd7, 18'd0, 2'b11);
    wr_load(6'd7, 18'h3FFFF, 2'b00);
    wr_load(6'd7, 18'h00000, 2'b10);       // lane 0 only
    rd_load(6'd7, d1, 2'b01);              // lane 1 only
    chk("R4 per-lane write", dout, {d1[17:9], 9'h000});
    idle(18'd0, 2'b11);
  endtask

  task automatic t_select();
    logic [2:0] bad [3];
    bad[0] = 3'b110; bad[1] = 3'b000; bad[2] = 3'b011;
    for (int i = 0; i < 3; i++) begin
      drv(1'b0, 1'b0, 1'b0, bad[i], 1'b0, 6'd7, 18'd0, 2'b11);
      chk("R5 doe on deselected write", {17'd0, doe}, 18'd0);
      idle(18'h00000, 2'b00);
      drv(1'b0, 1'b0, 1'b1, bad[i], 1'b0, 6'd7, 18'd0, 2'b11);
      chk("R5 doe on deselected read", {17'd0, doe}, 18'd0);
    end
    rd_load(6'd7, 18'd0, 2'b11);
    chk("R5 word unchanged", dout, {18'h15555 & 18'h3FE00});
    idle(18'd0, 2'b11);
  endtask

  task automatic t_burst();
    logic [1:0] lo;
    // fill 8..11 with distinct words
    for (int i = 8; i < 12; i++) begin
      wr_load(6'(i), (i == 8) ? 18'd0 : 18'(18'h100 + i - 1), 2'b00);
    end
    idle(18'h10B, 2'b00);
    // linear from 10
    drv(1'b0, 1'b0, 1'b1, CE_ON, 1'b0, 6'd10, 18'd0, 2'b11);
    for (int n = 0; n < 4; n++) begin
      lo = 2'(2'd2 + 2'(n));
      chk("R7 R9 linear step", dout, 18'(18'h100 + 8 + lo));
      if (n < 3) drv(1'b0, 1'b1, 1'b0, 3'b110, 1'b1, 6'd0, 18'd0, 2'b00);
    end
    // interleaved from 9
    drv(1'b0, 1'b0, 1'b1, CE_ON, 1'b1, 6'd9, 18'd0, 2'b11);
    for (int n = 0; n < 4; n++) begin
      lo = 2'd1 ^ 2'(n);
      chk("R8 R9 interleaved step", dout, 18'(18'h100 + 8 + lo));
      if (n < 3) drv(1'b0, 1'b1, 1'b0, 3'b110, 1'b0, 6'd0, 18'd0, 2'b00);
    end
    // write burst from 4, linear
    drv(1'b0, 1'b0, 1'b0, CE_ON, 1'b0, 6'd4, 18'd0, 2'b11);
    for (int n = 0; n < 3; n++) begin
      drv(1'b0, 1'b1, 1'b1, 3'b110, 1'b1, 6'd0, 18'(18'h200 + n), 2'b00);
      chk("R6 write burst keeps doe low", {17'd0, doe}, 18'd0);
    end
    rd_load(6'd4, 18'h203, 2'b00);
    for (int n = 0; n < 4; n++) begin
      chk("R6 write burst contents", dout, 18'(18'h200 + n));
      if (n < 3) drv(1'b0, 1'b1, 1'b0, 3'b110, 1'b0, 6'd0, 18'd0, 2'b00);
    end
    idle(18'd0, 2'b11);
  endtask

  task automatic t_suspend();
    // pending write held across suspend
    wr_load(6'd20, 18'd0, 2'b11);
    drv(1'b1, 1'b0, 1'b1, CE_ON, 1'b0, 6'd21, 18'h3C3C3, 2'b00);
    drv(1'b1, 1'b1, 1'b1, CE_ON, 1'b1, 6'd22, 18'h1E1E1, 2'b00);
    chk("R10 doe held during suspended write", {17'd0, doe}, 18'd0);
    rd_load(6'd20, 18'h0ABCD, 2'b00);
    chk("R10 R12 write after suspend", dout, 18'h0ABCD);
    // read output held across suspend
    drv(1'b1, 1'b0, 1'b1, CE_ON, 1'b0, 6'd9, 18'd0, 2'b11);
    chk("R10 driven word holds", dout, 18'h0ABCD);
    chk("R10 doe holds", {17'd0, doe}, 18'd1);
    drv(1'b1, 1'b0, 1'b0, 3'b110, 1'b0, 6'd9, 18'd0, 2'b00);
    chk("R10 deselect ignored", dout, 18'h0ABCD);
    idle(18'd0, 2'b11);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_rw_basic();
    t_bytes();
    t_select();
    t_burst();
    t_suspend();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule